// File: doc/BRIEF.md
# Serial 0-1-1 Pattern Detector with Progress Display

This block watches a serial bit stream, taking one bit on every rising clock edge, and looks for the pattern zero, one, one. It does not raise a single detect flag. It drives a three-bit thermometer code that shows how far the current match has progressed. No bits matched reads 000. The leading zero reads 001. Zero then one reads 011. The full pattern reads 111. Each output bit can drive an indicator lamp directly.

The machine is Moore-type. Its progress outputs are decoded from two state flip-flops and nothing else, so they change only at a clock edge. The state encoding follows a Gray-style order, so that most moves flip a single state bit. A zero always counts as a fresh start of a match, so overlapping streams such as 0110110 are tracked correctly. A one that arrives after a full match returns the machine to the idle state. A synchronous active-low reset returns the machine to idle.

Top module: `seq_progress_detector`

## Requirements
- R1: When `rst_n` is low at a rising edge, `progress` reads 000 after that edge, whatever the value of `bit_in`.
- R2: `progress` reads 000 when idle, 001 after a leading zero, 011 after zero-one, and 111 after zero-one-one. Bit 0 is the lowest lamp.
- R3: `progress` changes only at rising clock edges. Changes on `bit_in` between edges leave it unchanged.
- R4: From the idle level (000), a 0 moves to 001 and a 1 stays at 000.
- R5: From level 001, a 0 stays at 001 and a 1 moves to 011.
- R6: From level 011, a 0 falls back to 001 and a 1 moves to 111.
- R7: From level 111, a 0 moves to 001 because it starts a new match, and a 1 moves to 000.
- R8: Out of reset, `progress` only ever holds one of the four thermometer codes 000, 001, 011 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `bit_in` is sampled here |
| rst_n | input | 1 | Synchronous active-low reset to the idle state |
| bit_in | input | 1 | Serial data bit |
| progress | output | 3 | Thermometer count of pattern bits matched |

## Verification
The bench builds the block with its default progress width of three. That width gives each of the four states its own lamp pattern, so every transition out of every state can be seen on the ports. Directed overlapping streams such as 0110110 and runs of ones after a full match reach the restart and fall-back arcs. A long random stream with occasional resets covers the rest. Mid-cycle toggles of the input show that the outputs do not follow `bit_in` between edges.

// File: rtl/seq_det_pkg.sv
// Package: shared state type for the serial progress detector.
// Assumes a two-bit state register with a Gray-style assignment.
package seq_det_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 2'b00,
        ST_ZERO     = 2'b01,
        ST_ZERO_ONE = 2'b11,
        ST_FULL     = 2'b10
    } seq_state_e;
endpackage

// File: rtl/seq_next_state.sv
// Module: next-state logic of the detector.
// A zero always restarts a match. A one extends a partial match or
// clears the machine. Pure combinational logic.
module seq_next_state
    import seq_det_pkg::*;
(
    input  seq_state_e cur_state,
    input  logic       bit_in,
    output seq_state_e nxt_state
);
    // Choose the successor state from the present state and input bit.
    always_comb begin
        if (!bit_in) begin
            nxt_state = ST_ZERO;
        end else begin
            unique case (cur_state)
                ST_IDLE:     nxt_state = ST_IDLE;
                ST_ZERO:     nxt_state = ST_ZERO_ONE;
                ST_ZERO_ONE: nxt_state = ST_FULL;
                ST_FULL:     nxt_state = ST_IDLE;
                default:     nxt_state = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_state_reg.sv
// Module: state flip-flops with synchronous active-low reset.
// Assumes rst_n is already synchronous to clk.
module seq_state_reg
    import seq_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e nxt_state,
    output seq_state_e cur_state
);
    // Hold the present state; clear it to idle on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= ST_IDLE;
        else        cur_state <= nxt_state;
    end
endmodule

// File: rtl/seq_progress_decode.sv
// Module: turns the state into a thermometer lamp code.
// The output depends only on state (Moore). Bit i lights once more
// than i pattern bits have matched.
module seq_progress_decode
    import seq_det_pkg::*;
#(
    parameter int PROG_W = 3
) (
    input  seq_state_e        cur_state,
    output logic [PROG_W-1:0] progress
);
    localparam int LVL_W = $clog2(PROG_W + 1);

    logic [LVL_W-1:0] level;

    // Map each state to the number of pattern bits it has matched.
    always_comb begin
        unique case (cur_state)
            ST_IDLE:     level = LVL_W'(0);
            ST_ZERO:     level = LVL_W'(1);
            ST_ZERO_ONE: level = LVL_W'(2);
            ST_FULL:     level = LVL_W'(3);
            default:     level = LVL_W'(0);
        endcase
    end

    // Spread the match count into one lamp per position.
    for (genvar i = 0; i < PROG_W; i++) begin : g_lamp
        assign progress[i] = (level > LVL_W'(i));
    end
endmodule

// File: rtl/seq_progress_detector.sv
// Module: top of the serial 0-1-1 progress detector.
// One bit is sampled per rising edge. rst_n is synchronous and active low.
// progress is a thermometer code that changes only at clock edges.
module seq_progress_detector
    import seq_det_pkg::*;
#(
    parameter int PROG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [PROG_W-1:0] progress
);
    seq_state_e cur_state;
    seq_state_e nxt_state;

    seq_next_state u_next (
        .cur_state (cur_state),
        .bit_in    (bit_in),
        .nxt_state (nxt_state)
    );

    seq_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    seq_progress_decode #(.PROG_W(PROG_W)) u_dec (
        .cur_state (cur_state),
        .progress  (progress)
    );

    // Reset clears the lamps on the following cycle.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> progress == 3'b000);

    // Only thermometer codes ever appear.
    p_thermo_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(progress ^ (progress >> 1)) <= 1 && (progress[0] || progress == 3'b000));

    // Arcs leaving idle.
    p_idle_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        progress == 3'b000 |=> progress == ($past(bit_in) ? 3'b000 : 3'b001));

    // Arcs leaving the zero-seen level.
    p_zero_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        progress == 3'b001 |=> progress == ($past(bit_in) ? 3'b011 : 3'b001));

    // Arcs leaving the zero-one level.
    p_zero_one_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        progress == 3'b011 |=> progress == ($past(bit_in) ? 3'b111 : 3'b001));

    // Arcs leaving the full-match level.
    p_full_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        progress == 3'b111 |=> progress == ($past(bit_in) ? 3'b000 : 3'b001));
endmodule

// File: tb/seq_progress_detector_tb_top.sv
// Bench: behavioural reference that tracks the matched prefix length,
// compared against the lamps on every clock.
module seq_progress_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic [2:0] progress;

    int n_checks = 0;
    int n_fails  = 0;
    int ref_len  = 0;

    always #4 clk = ~clk;

    seq_progress_detector dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .progress (progress)
    );

    function automatic logic [2:0] lamps(input int len);
        return 3'((1 << len) - 1);
    endfunction

    function automatic int advance(input int len, input logic b);
        if (!b)            return 1;
        else if (len == 1) return 2;
        else if (len == 2) return 3;
        else               return 0;
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_checks++;
        if (progress !== exp) begin
            n_fails++;
            $display("FAIL %s: progress=%b expected=%b at %0t", req, progress, exp, $time);
        end
    endtask

    // Check the current lamps at the negedge, then apply one bit for the next edge.
    task automatic step(input string req, input logic b, input logic rst_v);
        @(negedge clk);
        check(req, lamps(ref_len));
        rst_n  = rst_v;
        bit_in = b;
        ref_len = rst_v ? advance(ref_len, b) : 0;
    endtask

    // Same as step, but wiggle bit_in before settling, checking the lamps hold (R3).
    task automatic step_glitch(input logic b);
        logic [2:0] held;
        @(negedge clk);
        check("R3", lamps(ref_len));
        held = progress;
        rst_n = 1'b1;
        bit_in = ~b;
        #1 check("R3", held);
        bit_in = b;
        #1 check("R3", held);
        bit_in = ~b;
        #1 check("R3", held);
        bit_in = b;
        ref_len = advance(ref_len, b);
    endtask

    task automatic stream(input string req, input string bits);
        for (int i = 0; i < bits.len(); i++)
            step(req, bits[i] == "1", 1'b1);
    endtask

    initial begin : watchdog
        #400000;
        n_fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        // R1: reset with bit_in high, then low.
        step("R1", 1'b1, 1'b0);
        step("R1", 1'b0, 1'b0);
        step("R1", 1'b1, 1'b1);
        // R4: ones hold idle, zero advances.
        stream("R4", "1110");
        // R5: zeros hold at 001, then a one.
        stream("R5", "0001");
        // R6: fall back from 011 on a zero.
        stream("R6", "0100");
        // R6 and R2: reach the full match.
        stream("R2", "011");
        // R7: one after a full match returns to idle.
        stream("R7", "1");
        // R7: zero after a full match restarts.
        stream("R7", "0110");
        // Overlapping streams.
        stream("R2", "0110110");
        stream("R8", "011011011");
        // R3: mid-cycle input changes do not reach the lamps.
        step_glitch(1'b0);
        step_glitch(1'b1);
        step_glitch(1'b1);
        step_glitch(1'b1);
        // R1: reset from the full-match level.
        stream("R2", "011");
        step("R1", 1'b0, 1'b0);
        step("R1", 1'b1, 1'b1);
        // Random stream with sparse resets.
        for (int i = 0; i < 3000; i++)
            step("R8", 1'($urandom_range(1)), ($urandom_range(99) != 0));
        @(negedge clk);
        check("R2", lamps(ref_len));
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule